// File: doc/BRIEF.md
# Adapter Setup Register File with Pin Crosspoint

This block gives an expansion-bus adapter its six byte-wide setup registers. The host reaches them with I/O cycles that carry the setup-select line. Offsets 0 and 1 hold a fixed board identifier. Offset 2 bit 0 enables the card. Offset 5 bit 7 is a channel-check flag: it drives an active-low error line and is cleared by a set-check input. The remaining 30 bits are for the user. A crosspoint, fixed by a parameter, routes any of those bits to any of 16 open-drain I/O pins. A stored 0 pulls its pin low. A stored 1 releases the pin, so board logic can drive it, and a read of that bit returns the live pin level.

The bus lines are sampled on the block clock. The cycle type and the setup select are captured when the address-latch strobe falls. The register offset is captured when that strobe rises. Write data is taken when the command strobe rises. Read data is driven, together with the output enable of the data port, while the command strobe is low. Two strobes, one for setup reads and one for setup writes, follow the command strobe so that external option logic can use them. Channel reset cancels the cycle at once and returns every register to its default.

Top module: `cfg_regfile_xbar`

## Requirements
- R1: A setup read of offset 0 returns BOARD_ID[7:0] and offset 1 returns BOARD_ID[15:8]; setup writes to offsets 0 and 1 change nothing.
- R2: The cycle code {mio, st0, st1} decodes as 001 = I/O write and 010 = I/O read. A register access happens only for these two codes with setup_n low and offsets 0 to 5. Memory codes (101 write, 110 read), all other codes, and offsets 6 and 7 cause no strobe, no data drive and no register change.
- R3: The cycle code and setup_n are taken at the first clock on which adl_n is seen low after being high. addr is taken when adl_n is seen high again. Changes to these lines after their capture point do not affect the cycle.
- R4: A setup write updates the register on the clock edge at which cmd_n is first seen high after being low; until that edge the old value stays in effect.
- R5: d_oe is 1 only while cmd_n is low during a setup I/O read of offsets 0 to 5. d_out is 0 whenever d_oe is 0.
- R6: Card enable is offset 2 bit 0. It is 0 after channel reset, brd_en_n is low exactly when it is 1, and I/O writes without setup_n low leave it unchanged.
- R7: The check flag is offset 5 bit 7 and chck_n equals its value. Channel reset sets it and a setup write loads it. setchk_n sampled low clears it on the next edge, and this takes priority over a write on the same edge.
- R8: In the default map, pin p for p from 0 to 13 carries user bit p+1, where user bit k is offset 2+k/8, bit k%8. Pin 14 also carries bit 1 and pin 15 is unrouted. gpio_pull[p] is 1 exactly when pin p is routed and its bit is 0.
- R9: Reading a routed bit returns the level on gpio_in (the AND of all pins routed to it). Driving a pin low from outside never changes the stored bit.
- R10: rdcfg_n is low exactly while d_oe is 1. wrcfg_n is low while cmd_n is low during a setup I/O write of offsets 0 to 5. The two strobes are never low together.
- R11: While chan_rst is high, d_oe, rdcfg_n and wrcfg_n are inactive in the same cycle, and the cycle in progress is cancelled, so a later rise of cmd_n writes nothing.
- R12: After channel reset every user bit and the check flag are 1, so offset 2 reads 0xFE and offsets 3 to 5 read 0xFF. Unrouted bits read back their stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| chan_rst | input | 1 | Channel reset, active high, synchronous for state and immediate for outputs |
| adl_n | input | 1 | Address-latch strobe, active low |
| cmd_n | input | 1 | Command strobe, active low |
| setup_n | input | 1 | Setup select, active low |
| mio | input | 1 | Memory (1) or I/O (0) cycle |
| st0 | input | 1 | Bus status line 0 |
| st1 | input | 1 | Bus status line 1 |
| addr | input | 3 | Low address bits selecting the offset |
| d_in | input | 8 | Write data from the bus |
| d_out | output | 8 | Read data toward the bus |
| d_oe | output | 1 | Data port drive enable |
| rdcfg_n | output | 1 | Setup read strobe for external option logic |
| wrcfg_n | output | 1 | Setup write strobe for external option logic |
| setchk_n | input | 1 | Clears the check flag when low |
| brd_en_n | output | 1 | Board enable, low when the card is enabled |
| chck_n | output | 1 | Channel-check line level, low on error |
| gpio_in | input | 16 | Sensed level of the open-drain pins |
| gpio_pull | output | 16 | Pull-low enable of each open-drain pin |

## Verification
Two operations on the check flag can land on the same clock edge: a set-check pulse and a setup write that sets the flag. The bench lowers setchk_n in the same cycle that it raises cmd_n on a write of 0x80 to offset 5, and then expects chck_n low. It then sets the flag again and repeats the pulse on its own, so that each operation is shown to act separately. A second collision, channel reset arriving while a write command is still low, is judged by the strobes in that same cycle and by a read afterwards that must show the default value and not the written one.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int NUM_OFS    = 6;
    localparam int OFS_W      = 3;
    localparam int USER_BASE  = 2;
    localparam int USER_BYTES = 4;
    localparam int USER_BITS  = USER_BYTES * 8;
    localparam int IDX_W      = $clog2(USER_BITS);
    localparam int ENT_W      = IDX_W + 1;
    localparam int NUM_PINS   = 16;
    localparam int ENABLE_IDX = 0;
    localparam int CHECK_IDX  = USER_BITS - 1;

    typedef enum logic [2:0] {
        CY_NOP    = 3'd0,
        CY_IO_RD  = 3'd1,
        CY_IO_WR  = 3'd2,
        CY_MEM_RD = 3'd3,
        CY_MEM_WR = 3'd4
    } cyc_kind_e;

    typedef struct packed {
        logic             setup;
        logic             live;
        cyc_kind_e        kind;
        logic [OFS_W-1:0] ofs;
    } cyc_t;

    function automatic cyc_kind_e decode_kind(input logic [2:0] code);
        case (code)
            3'b001:  return CY_IO_WR;
            3'b010:  return CY_IO_RD;
            3'b101:  return CY_MEM_WR;
            3'b110:  return CY_MEM_RD;
            default: return CY_NOP;
        endcase
    endfunction

    function automatic logic routable(input logic [IDX_W-1:0] idx);
        return (idx != IDX_W'(ENABLE_IDX)) && (idx != IDX_W'(CHECK_IDX));
    endfunction

    function automatic logic [NUM_PINS*ENT_W-1:0] default_map();
        logic [NUM_PINS*ENT_W-1:0] m;
        m = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (p < 14)
                m[p*ENT_W +: ENT_W] = {1'b1, IDX_W'(p + 1)};
            else if (p == 14)
                m[p*ENT_W +: ENT_W] = {1'b1, IDX_W'(1)};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_cycle_decode.sv
module cfg_cycle_decode
    import cfg_pkg::*;
(
    input  logic             clk,
    input  logic             chan_rst,
    input  logic             adl_n,
    input  logic             cmd_n,
    input  logic             setup_n,
    input  logic             mio,
    input  logic             st0,
    input  logic             st1,
    input  logic [OFS_W-1:0] addr,
    output cyc_t             cyc,
    output logic             rd_act,
    output logic             wr_act,
    output logic             wr_pulse
);

    logic adl_q;
    logic cmd_q;
    logic hit;

    always_ff @(posedge clk) begin
        if (chan_rst) begin
            adl_q <= 1'b1;
            cmd_q <= 1'b1;
            cyc   <= '{setup: 1'b0, live: 1'b0, kind: CY_NOP, ofs: '0};
        end else begin
            adl_q <= adl_n;
            cmd_q <= cmd_n;
            if (adl_q && !adl_n) begin
                cyc.setup <= !setup_n;
                cyc.kind  <= decode_kind({mio, st0, st1});
                cyc.live  <= 1'b0;
            end
            if (!adl_q && adl_n) begin
                cyc.ofs  <= addr;
                cyc.live <= 1'b1;
            end
        end
    end

    always_comb begin
        hit      = cyc.live && cyc.setup && (cyc.ofs < OFS_W'(NUM_OFS)) && !chan_rst;
        rd_act   = hit && (cyc.kind == CY_IO_RD) && !cmd_n;
        wr_act   = hit && (cyc.kind == CY_IO_WR) && !cmd_n;
        wr_pulse = hit && (cyc.kind == CY_IO_WR) && cmd_n && !cmd_q;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 chan_rst,
    input  logic                 wr_pulse,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [7:0]           wdata,
    input  logic                 setchk_n,
    output logic [USER_BITS-1:0] bits
);

    logic [USER_BYTES-1:0] byte_we;

    for (genvar g = 0; g < USER_BYTES; g++) begin : g_byte
        assign byte_we[g] = wr_pulse && (ofs == OFS_W'(USER_BASE + g));

        always_ff @(posedge clk) begin
            if (chan_rst) begin
                bits[g*8 +: 8] <= (g == ENABLE_IDX / 8) ? ~(8'd1 << (ENABLE_IDX % 8)) : 8'hFF;
            end else if (byte_we[g]) begin
                if (g == CHECK_IDX / 8) begin
                    for (int b = 0; b < 8; b++)
                        if (g*8 + b == CHECK_IDX)
                            bits[g*8+b] <= wdata[b] && setchk_n;
                        else
                            bits[g*8+b] <= wdata[b];
                end else begin
                    bits[g*8 +: 8] <= wdata;
                end
            end else if (g == CHECK_IDX / 8 && !setchk_n) begin
                bits[CHECK_IDX] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfg_crosspoint.sv
module cfg_crosspoint
    import cfg_pkg::*;
#(
    parameter logic [NUM_PINS*ENT_W-1:0] PIN_MAP = default_map()
) (
    input  logic [USER_BITS-1:0] bits,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_pull,
    output logic [USER_BITS-1:0] view
);

    logic [NUM_PINS-1:0] routed;
    logic [IDX_W-1:0]    pin_idx [NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [ENT_W-1:0] ENT = PIN_MAP[p*ENT_W +: ENT_W];
        assign pin_idx[p]  = ENT[IDX_W-1:0];
        assign routed[p]   = ENT[ENT_W-1] && routable(ENT[IDX_W-1:0]);
        assign pin_pull[p] = routed[p] && !bits[pin_idx[p]];
    end

    always_comb begin
        logic [USER_BITS-1:0] seen;
        seen = '0;
        view = bits;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (routed[p]) begin
                if (seen[pin_idx[p]])
                    view[pin_idx[p]] = view[pin_idx[p]] & pin_in[p];
                else
                    view[pin_idx[p]] = pin_in[p];
                seen[pin_idx[p]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_regfile_xbar.sv
module cfg_regfile_xbar
    import cfg_pkg::*;
#(
    parameter logic [15:0]               BOARD_ID = 16'hA5C3,
    parameter logic [NUM_PINS*ENT_W-1:0] PIN_MAP  = default_map()
) (
    input  logic                clk,
    input  logic                chan_rst,
    input  logic                adl_n,
    input  logic                cmd_n,
    input  logic                setup_n,
    input  logic                mio,
    input  logic                st0,
    input  logic                st1,
    input  logic [OFS_W-1:0]    addr,
    input  logic [7:0]          d_in,
    output logic [7:0]          d_out,
    output logic                d_oe,
    output logic                rdcfg_n,
    output logic                wrcfg_n,
    input  logic                setchk_n,
    output logic                brd_en_n,
    output logic                chck_n,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [NUM_PINS-1:0] gpio_pull
);

    cyc_t                 cyc;
    logic                 rd_act;
    logic                 wr_act;
    logic                 wr_pulse;
    logic [USER_BITS-1:0] bits;
    logic [USER_BITS-1:0] view;
    logic [7:0]           rd_byte;

    cfg_cycle_decode u_dec (
        .clk      (clk),
        .chan_rst (chan_rst),
        .adl_n    (adl_n),
        .cmd_n    (cmd_n),
        .setup_n  (setup_n),
        .mio      (mio),
        .st0      (st0),
        .st1      (st1),
        .addr     (addr),
        .cyc      (cyc),
        .rd_act   (rd_act),
        .wr_act   (wr_act),
        .wr_pulse (wr_pulse)
    );

    cfg_reg_bank u_bank (
        .clk      (clk),
        .chan_rst (chan_rst),
        .wr_pulse (wr_pulse),
        .ofs      (cyc.ofs),
        .wdata    (d_in),
        .setchk_n (setchk_n),
        .bits     (bits)
    );

    cfg_crosspoint #(
        .PIN_MAP (PIN_MAP)
    ) u_xbar (
        .bits     (bits),
        .pin_in   (gpio_in),
        .pin_pull (gpio_pull),
        .view     (view)
    );

    always_comb begin
        case (cyc.ofs)
            3'd0:    rd_byte = BOARD_ID[7:0];
            3'd1:    rd_byte = BOARD_ID[15:8];
            3'd2:    rd_byte = view[7:0];
            3'd3:    rd_byte = view[15:8];
            3'd4:    rd_byte = view[23:16];
            3'd5:    rd_byte = view[31:24];
            default: rd_byte = 8'h00;
        endcase
    end

    assign d_oe     = rd_act;
    assign d_out    = rd_act ? rd_byte : 8'h00;
    assign rdcfg_n  = !rd_act;
    assign wrcfg_n  = !wr_act;
    assign brd_en_n = !bits[ENABLE_IDX];
    assign chck_n   = bits[CHECK_IDX];

endmodule

// File: rtl/cfg_regfile_xbar_chk.sv
module cfg_regfile_xbar_chk (
    input logic clk,
    input logic chan_rst,
    input logic cmd_n,
    input logic setchk_n,
    input logic d_oe,
    input logic rdcfg_n,
    input logic wrcfg_n,
    input logic brd_en_n,
    input logic chck_n
);

    AST_DOE_NEEDS_CMD: assert property (@(posedge clk) disable iff (chan_rst)
        d_oe |-> !cmd_n); // R5

    AST_DOE_WITH_RDSTB: assert property (@(posedge clk) disable iff (chan_rst)
        d_oe |-> !rdcfg_n); // R10

    AST_WRSTB_NEEDS_CMD: assert property (@(posedge clk) disable iff (chan_rst)
        !wrcfg_n |-> !cmd_n); // R10

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (chan_rst)
        (rdcfg_n || wrcfg_n)); // R10

    AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (chan_rst)
        $past(chan_rst) |-> brd_en_n); // R6

    AST_SETCHK_CLEARS: assert property (@(posedge clk) disable iff (chan_rst)
        !setchk_n |=> !chck_n); // R7

    always @(posedge clk) begin
        if (chan_rst === 1'b1) begin
            AST_RESET_QUIET: assert (!d_oe && rdcfg_n && wrcfg_n); // R11
        end
    end

endmodule

bind cfg_regfile_xbar cfg_regfile_xbar_chk u_chk (
    .clk      (clk),
    .chan_rst (chan_rst),
    .cmd_n    (cmd_n),
    .setchk_n (setchk_n),
    .d_oe     (d_oe),
    .rdcfg_n  (rdcfg_n),
    .wrcfg_n  (wrcfg_n),
    .brd_en_n (brd_en_n),
    .chck_n   (chck_n)
);

// File: tb/tb_cfg_regfile_xbar.sv
`timescale 1ns/1ps
module tb_cfg_regfile_xbar;

    logic        clk = 1'b0;
    logic        chan_rst = 1'b1;
    logic        adl_n = 1'b1, cmd_n = 1'b1, setup_n = 1'b1;
    logic        mio = 1'b0, st0 = 1'b0, st1 = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  d_in = '0;
    logic [7:0]  d_out;
    logic        d_oe, rdcfg_n, wrcfg_n, brd_en_n, chck_n;
    logic        setchk_n = 1'b1;
    logic [15:0] gpio_in, gpio_pull;
    logic [15:0] ext_low = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    // open-drain pins with pull-ups: low when the block or the board pulls them
    assign gpio_in = ~gpio_pull & ~ext_low;

    cfg_regfile_xbar dut (
        .clk(clk), .chan_rst(chan_rst), .adl_n(adl_n), .cmd_n(cmd_n),
        .setup_n(setup_n), .mio(mio), .st0(st0), .st1(st1), .addr(addr),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .rdcfg_n(rdcfg_n),
        .wrcfg_n(wrcfg_n), .setchk_n(setchk_n), .brd_en_n(brd_en_n),
        .chck_n(chck_n), .gpio_in(gpio_in), .gpio_pull(gpio_pull)
    );

    // {setup, code, ofs, wdata, expected read}
    localparam int NV = 24;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 3'b010, 3'd0, 8'h00, 8'hC3},
        {1'b1, 3'b010, 3'd1, 8'h00, 8'hA5},
        {1'b1, 3'b001, 3'd0, 8'h55, 8'h00},
        {1'b1, 3'b001, 3'd1, 8'h55, 8'h00},
        {1'b1, 3'b010, 3'd0, 8'h00, 8'hC3},
        {1'b1, 3'b010, 3'd1, 8'h00, 8'hA5},
        {1'b1, 3'b010, 3'd2, 8'h00, 8'hFE},
        {1'b1, 3'b010, 3'd5, 8'h00, 8'hFF},
        {1'b1, 3'b001, 3'd2, 8'h01, 8'h00},
        {1'b1, 3'b010, 3'd2, 8'h00, 8'h01},
        {1'b1, 3'b101, 3'd2, 8'hFF, 8'h00},
        {1'b1, 3'b010, 3'd2, 8'h00, 8'h01},
        {1'b0, 3'b001, 3'd2, 8'hFE, 8'h00},
        {1'b0, 3'b010, 3'd2, 8'h00, 8'h00},
        {1'b1, 3'b010, 3'd2, 8'h00, 8'h01},
        {1'b1, 3'b011, 3'd3, 8'h00, 8'h00},
        {1'b1, 3'b110, 3'd3, 8'h00, 8'h00},
        {1'b1, 3'b001, 3'd3, 8'h5A, 8'h00},
        {1'b1, 3'b010, 3'd3, 8'h00, 8'h5A},
        {1'b1, 3'b001, 3'd5, 8'h00, 8'h00},
        {1'b1, 3'b010, 3'd5, 8'h00, 8'h00},
        {1'b1, 3'b001, 3'd5, 8'h80, 8'h00},
        {1'b1, 3'b010, 3'd5, 8'h00, 8'h80},
        {1'b1, 3'b010, 3'd6, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected pin pulls for the default map, from offsets 2 and 3 (R8)
    function automatic logic [15:0] exp_pull(input logic [7:0] b2, input logic [7:0] b3);
        logic [15:0] r;
        logic [15:0] lo;
        lo = {b3, b2};
        r = '0;
        for (int p = 0; p < 14; p++) r[p] = !lo[p+1];
        r[14] = !b2[1];
        return r;
    endfunction

    logic [7:0]  rd;
    logic        oe, rs_n, ws_n;
    logic [15:0] mid_pull;

    task automatic bus_cyc(input logic su, input logic [2:0] code, input logic [2:0] ofs,
                           input logic [7:0] wd, input bit scramble, input bit chk_mid,
                           input bit rst_mid);
        setup_n = !su; {mio, st0, st1} = code; addr = ofs; adl_n = 1'b0;
        @(negedge clk); @(negedge clk);
        if (scramble) begin setup_n = su; {mio, st0, st1} = ~code; end
        adl_n = 1'b1;
        @(negedge clk);
        if (scramble) addr = ~ofs;
        d_in = wd; cmd_n = 1'b0;
        @(negedge clk);
        rd = d_out; oe = d_oe; rs_n = rdcfg_n; ws_n = wrcfg_n; mid_pull = gpio_pull;
        if (rst_mid) begin
            chan_rst = 1'b1;
            #1;
            check("R11 quiet strobes", {d_oe, rdcfg_n, wrcfg_n}, 3'b011);
            @(negedge clk);
            chan_rst = 1'b0;
            @(negedge clk);
        end
        cmd_n = 1'b1;
        if (chk_mid) setchk_n = 1'b0;
        @(negedge clk);
        setchk_n = 1'b1; setup_n = 1'b1; {mio, st0, st1} = 3'b000;
        @(negedge clk);
    endtask

    task automatic read_ofs(input logic [2:0] ofs);
        bus_cyc(1'b1, 3'b010, ofs, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic write_ofs(input logic [2:0] ofs, input logic [7:0] wd);
        bus_cyc(1'b1, 3'b001, ofs, wd, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chan_rst = 1'b0;
        @(negedge clk);

        check("R6 reset enable", brd_en_n, 1'b1);
        check("R7 reset flag", chck_n, 1'b1);
        check("R12 reset pins released", gpio_pull, 16'h0000);
        check("R5 reset no drive", d_oe, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic        su;
            logic [2:0]  code, ofs;
            logic [7:0]  wd, ex;
            logic        e_rd, e_wr;
            {su, code, ofs, wd, ex} = VEC[i];
            bus_cyc(su, code, ofs, wd, 1'b0, 1'b0, 1'b0);
            e_rd = su && code == 3'b010 && ofs < 3'd6;
            e_wr = su && code == 3'b001 && ofs < 3'd6;
            check("R2 R5 drive enable", oe, e_rd);
            check("R10 read strobe", rs_n, !e_rd);
            check("R10 write strobe", ws_n, !e_wr);
            if (e_rd) check((ofs < 3'd2) ? "R1 id read" : "R12 register read", rd, ex);
            else      check("R5 idle data", rd, 8'h00);
        end

        check("R6 enabled", brd_en_n, 1'b0);
        check("R7 flag set by write", chck_n, 1'b1);
        check("R8 pin map", gpio_pull, exp_pull(8'h01, 8'h5A));

        bus_cyc(1'b1, 3'b010, 3'd1, 8'h00, 1'b1, 1'b0, 1'b0);
        check("R3 late line changes", {oe, rd}, {1'b1, 8'hA5});

        write_ofs(3'd2, 8'hFF);
        check("R8 pins released", gpio_pull, exp_pull(8'hFF, 8'h5A));
        ext_low = 16'h0008;
        read_ofs(3'd2);
        check("R9 pin level read", rd, 8'hEF);
        ext_low = 16'h4000;
        read_ofs(3'd2);
        check("R9 shared pin read", rd, 8'hFD);
        ext_low = 16'h0000;
        read_ofs(3'd2);
        check("R9 stored bit kept", rd, 8'hFF);

        write_ofs(3'd3, 8'h00);
        check("R4 old value before edge", mid_pull, exp_pull(8'hFF, 8'h5A));
        check("R4 new value after edge", gpio_pull, exp_pull(8'hFF, 8'h00));

        bus_cyc(1'b1, 3'b001, 3'd5, 8'h80, 1'b0, 1'b1, 1'b0);
        check("R7 set-check beats write", chck_n, 1'b0);
        write_ofs(3'd5, 8'h80);
        check("R7 write sets flag", chck_n, 1'b1);
        setchk_n = 1'b0;
        @(negedge clk);
        setchk_n = 1'b1;
        check("R7 pulse clears flag", chck_n, 1'b0);
        read_ofs(3'd5);
        check("R7 flag read", rd, 8'h00);

        bus_cyc(1'b1, 3'b001, 3'd3, 8'h11, 1'b0, 1'b0, 1'b1);
        read_ofs(3'd3);
        check("R11 cancelled write", rd, 8'hFF);
        read_ofs(3'd2);
        check("R12 reset default", rd, 8'hFE);
        check("R6 reset clears enable", brd_en_n, 1'b1);
        check("R7 reset sets flag", chck_n, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule